// File: doc/BRIEF.md
# Masked Interrupt Event Aggregator

This block collects interrupt events for a network controller and turns them into thirteen separate interrupt request lines. Event sources inside the controller raise bits of a 32-bit event register with single-cycle set pulses. Software reads the event register to see what happened, and it acknowledges events by writing ones to the bits it wants to clear. A 32-bit mask register selects which events may reach the outputs.

Each output line follows one event bit in a fixed, non-monotonic order. The line is high when that bit is both pending and enabled in the mask. The outputs are registered, and each line's flop loads only when its value is about to change. Software reaches both registers through a simple word-addressed read/write port.

Top module: `irq_event_agg`

## Requirements
- R1: After reset the event register and the mask register both read as zero, and all thirteen lines are low.
- R2: A set pulse on bit n, for n from 19 to 31, sets event bit n. Set pulses on bits 18 down to 0 are ignored, and those bits always read as zero.
- R3: A write to offset 0x004 clears every event bit whose write-data bit is 1. Event bits whose write-data bit is 0 keep their value.
- R4: A write to offset 0x008 replaces all 32 mask bits, and reading offset 0x008 returns the value written.
- R5: When a set pulse and a write-1 clear hit the same event bit in the same cycle, the bit ends up set.
- R6: Line i is high exactly when its source bit is set in both the event and mask registers. The source bits for lines 0 to 12 are 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29 and 30.
- R7: The lines change one clock cycle after the event or mask register changes.
- R8: A write to any offset other than 0x004 or 0x008 changes neither register. A read of such an offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set_i | input | 32 | Per-bit event set pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 10 | Byte offset of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 13 | Interrupt request lines |

## Verification
A single-bit sweep pulses each of the 32 event positions in turn with the mask fully open. This separates the implemented bits from the dead low bits, and it pins each line to exactly one source. A mask sweep then fills the event register and opens one mask bit at a time. This shows that the AND gating and the line order hold from the mask side as well. Directed patterns cover a partial write-1 clear, a set racing a clear on the same bit, writes to an unused offset, and the one-cycle lag between a register change and the lines.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_LINES = 13;
    localparam int IMPL_LSB  = 19;

    // Event bit that drives each output line.
    function automatic int line_src(input int line);
        case (line)
            0:       return 27;
            1:       return 26;
            2:       return 19;
            3:       return 20;
            4:       return 25;
            5:       return 24;
            6:       return 23;
            7:       return 21;
            8:       return 31;
            9:       return 28;
            10:      return 22;
            11:      return 29;
            default: return 30;
        endcase
    endfunction

    function automatic logic [NUM_LINES-1:0] route(input logic [DATA_W-1:0] act);
        logic [NUM_LINES-1:0] r;
        for (int i = 0; i < NUM_LINES; i++) r[i] = act[line_src(i)];
        return r;
    endfunction

    typedef struct packed {
        logic [DATA_W-1:0] evt;
        logic [DATA_W-1:0] msk;
    } agg_regs_t;
endpackage

// File: rtl/agg_regfile.sv
module agg_regfile
    import irq_agg_pkg::*;
#(
    parameter int          ADDR_W  = 10,
    parameter logic [9:0]  EVT_OFS = 10'h004,
    parameter logic [9:0]  MSK_OFS = 10'h008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] evt_o,
    output logic [DATA_W-1:0] msk_o
);
    localparam logic [DATA_W-1:0] IMPL =
        {{(DATA_W-IMPL_LSB){1'b1}}, {IMPL_LSB{1'b0}}};

    agg_regs_t regs_d, regs_q;
    logic      evt_wr, msk_wr;

    assign evt_wr = wr_i && (addr_i == ADDR_W'(EVT_OFS));
    assign msk_wr = wr_i && (addr_i == ADDR_W'(MSK_OFS));

    always_comb begin
        regs_d = regs_q;
        if (evt_wr) regs_d.evt = regs_q.evt & ~wdata_i;
        // Set pulses are applied after the clear so a same-cycle set wins.
        regs_d.evt = (regs_d.evt | set_i) & IMPL;
        if (msk_wr) regs_d.msk = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign evt_o = regs_q.evt;
    assign msk_o = regs_q.msk;

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & IMPL) != '0) |=> ((regs_q.evt & $past(set_i & IMPL)) == $past(set_i & IMPL)));
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_wr && (set_i == '0)) |=> ((regs_q.evt & $past(wdata_i)) == '0));
    p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        msk_wr |=> (regs_q.msk == $past(wdata_i)));
    p_other_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !evt_wr && !msk_wr && (set_i == '0)) |=> ($stable(regs_q.evt) && $stable(regs_q.msk)));
    p_low_dead_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (regs_q.evt[IMPL_LSB-1:0] == '0));
endmodule

// File: rtl/agg_line_router.sv
module agg_line_router
    import irq_agg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_W-1:0]    evt_i,
    input  logic [DATA_W-1:0]    msk_i,
    output logic [NUM_LINES-1:0] lines_o
);
    logic [DATA_W-1:0]    active;
    logic [NUM_LINES-1:0] want, lines_d, lines_q;

    assign active = evt_i & msk_i;

    // Each line's flop loads only when the masked source disagrees with it.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_comb begin
            want[g]    = active[line_src(g)];
            lines_d[g] = (want[g] != lines_q[g]) ? want[g] : lines_q[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lines_q <= '0;
        else        lines_q <= lines_d;
    end

    assign lines_o = lines_q;

    p_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lines_q == route($past(evt_i & msk_i))));
endmodule

// File: rtl/irq_event_agg.sv
module irq_event_agg
    import irq_agg_pkg::*;
#(
    parameter int         ADDR_W  = 10,
    parameter logic [9:0] EVT_OFS = 10'h004,
    parameter logic [9:0] MSK_OFS = 10'h008
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_W-1:0]    evt_set_i,
    input  logic                 reg_wr_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [DATA_W-1:0]    reg_rdata_o,
    output logic [NUM_LINES-1:0] irq_o
);
    logic [DATA_W-1:0] evt, msk;

    agg_regfile #(.ADDR_W(ADDR_W), .EVT_OFS(EVT_OFS), .MSK_OFS(MSK_OFS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (evt_set_i),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .evt_o   (evt),
        .msk_o   (msk)
    );

    agg_line_router u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt),
        .msk_i   (msk),
        .lines_o (irq_o)
    );

    always_comb begin
        if (reg_addr_i == ADDR_W'(EVT_OFS))      reg_rdata_o = evt;
        else if (reg_addr_i == ADDR_W'(MSK_OFS)) reg_rdata_o = msk;
        else                                     reg_rdata_o = '0;
    end

    p_line_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o[0]) |-> $past(evt[27] && msk[27]));
endmodule

// File: tb/irq_event_agg_tb.sv
module irq_event_agg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_set = '0;
    logic        wr = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [12:0] irq;

    int checks = 0;
    int errors = 0;
    int src [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
    localparam logic [31:0] IMPL = 32'hFFF8_0000;

    always #5 clk = ~clk;

    irq_event_agg u_dut (
        .clk(clk), .rst_n(rst_n), .evt_set_i(evt_set), .reg_wr_i(wr),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [12:0] exp_lines(input logic [31:0] e, input logic [31:0] m);
        logic [12:0] r;
        for (int i = 0; i < 13; i++) r[i] = e[src[i]] & m[src[i]];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wreg(input logic [9:0] a, input logic [31:0] v);
        wr = 1'b1; addr = a; wdata = v;
        step();
        wr = 1'b0; wdata = '0;
    endtask

    task automatic pulse(input logic [31:0] v);
        evt_set = v;
        step();
        evt_set = '0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, ev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(10'h004, v); check("R1 event", v, 32'h0);
        rd(10'h008, v); check("R1 mask", v, 32'h0);
        check("R1 lines", {19'h0, irq}, 32'h0);

        wreg(10'h008, 32'h1234_5678);
        rd(10'h008, v); check("R4 mask load", v, 32'h1234_5678);
        wreg(10'h008, 32'hFFFF_FFFF);
        rd(10'h008, v); check("R4 mask replace", v, 32'hFFFF_FFFF);

        // Single-bit sweep over all event positions.
        for (int b = 0; b < 32; b++) begin
            pulse(32'h1 << b);
            ev = (32'h1 << b) & IMPL;
            rd(10'h004, v); check("R2 set bit", v, ev);
            check("R7 lines lag", {19'h0, irq}, 32'h0);
            step();
            check("R6 single line", {19'h0, irq}, {19'h0, exp_lines(ev, 32'hFFFF_FFFF)});
            wreg(10'h004, 32'h1 << b);
            rd(10'h004, v); check("R3 clear bit", v, 32'h0);
            step();
            check("R7 lines fall", {19'h0, irq}, 32'h0);
        end

        // Mask sweep with every event pending.
        pulse(32'hFFFF_FFFF);
        rd(10'h004, v); check("R2 all set", v, IMPL);
        for (int i = 0; i < 13; i++) begin
            wreg(10'h008, 32'h1 << src[i]);
            step();
            check("R6 mask one line", {19'h0, irq}, 32'h1 << i);
        end
        wreg(10'h008, 32'h0);
        step();
        check("R6 mask closed", {19'h0, irq}, 32'h0);

        // Partial write-1 clear.
        wreg(10'h004, 32'h5A50_0000);
        rd(10'h004, v); check("R3 partial clear", v, IMPL & ~32'h5A50_0000);

        // Set races clear on bit 25.
        wreg(10'h004, 32'hFFFF_FFFF);
        evt_set = 32'h0200_0000;
        wreg(10'h004, 32'h0200_0000);
        evt_set = '0;
        rd(10'h004, v); check("R5 set wins", v, 32'h0200_0000);

        // Unused offset.
        wreg(10'h008, 32'h00F0_0000);
        wreg(10'h00C, 32'hFFFF_FFFF);
        rd(10'h004, v); check("R8 event held", v, 32'h0200_0000);
        rd(10'h008, v); check("R8 mask held", v, 32'h00F0_0000);
        rd(10'h00C, v); check("R8 read zero", v, 32'h0);
        wreg(10'h008, 32'h0200_0000);
        step();
        check("R6 line 4", {19'h0, irq}, 32'h10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule